// File: doc/BRIEF.md
# Packet Receive Filter and Acknowledger

This block sits behind a frame-level receiver on a token-passing network node. It watches the decoded bytes of each incoming frame and decides what to do with the frame. An enquiry frame that asks whether this node has room for a packet gets an answer: a positive acknowledge when the node's receive path is open, or a negative acknowledge when it is closed. A data frame is examined once its start-of-header byte is seen. The block matches the destination ID against the node's own ID, against the broadcast ID 0 when broadcast reception is enabled, or against anything at all in monitor mode. It then copies the sender's ID and the packet body into a receive buffer through a plain write port.

When the frame ends, the receiver reports whether the CRC was good and how many body bytes it counted. A packet that passes both checks is marked received, and the receive path closes so that the buffer is not overwritten. A positive acknowledge goes back to the sender, except for broadcast packets, which are taken silently. Software reopens the receive path with a one-cycle clear pulse.

Top module: `rx_filter_ack`

## Requirements
- R1: After reset, rxInhibit, replyValid, replyAck, pktRcvd and bufWrEn are all 0.
- R2: A frame whose first byte is 0x85 and whose second byte equals myId gets, in the cycle after its rxEnd, replyValid=1 with replyAck=1 when receive is open and replyAck=0 (NAK) when rxInhibit is 1. An enquiry carrying any other ID gets no reply.
- R3: A frame whose first byte is neither 0x01 nor 0x85 causes no buffer write, no reply and no pktRcvd.
- R4: A data frame has the layout [0x01, source ID, destination ID, body...]. It is accepted when the destination equals myId, or when the destination is 0 and bcastEn=1, or when rcvAll=1. Otherwise it produces no buffer write.
- R5: For an accepted frame, the source ID is written at address 0 in the cycle after the destination byte, and body byte k (k from 0) is written at address k+1 in the cycle after that byte arrives.
- R6: At rxEnd of an accepted frame with rxCrcGood=1 and rxLen<=507 (0 included), pktRcvd pulses for one cycle in the next cycle, rxInhibit becomes 1, and replyValid=1 with replyAck=1 appears when the destination ID was not 0.
- R7: An accepted packet with destination ID 0 that passes both checks produces no reply.
- R8: A packet with rxCrcGood=0 or rxLen>507 produces no pktRcvd and no reply, and leaves rxInhibit unchanged.
- R9: While rxInhibit=1, a data frame is not accepted and produces no buffer write.
- R10: A clrInhibit pulse clears rxInhibit in the next cycle. When it coincides with the end of a packet that passes both checks, rxInhibit ends up 1. An enquiry ending in the same cycle as the pulse is answered with NAK.
- R11: Body bytes that would land at an address above 507 are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| myId | input | 8 | This node's ID |
| bcastEn | input | 1 | Accept packets sent to ID 0 |
| rcvAll | input | 1 | Monitor mode: accept any destination |
| rxValid | input | 1 | A frame byte is present on rxData |
| rxFirst | input | 1 | The present byte is the first of a frame |
| rxData | input | 8 | Frame byte |
| rxEnd | input | 1 | Frame finished (cycle without a byte) |
| rxCrcGood | input | 1 | CRC result, valid with rxEnd |
| rxLen | input | 10 | Body byte count, valid with rxEnd |
| clrInhibit | input | 1 | One-cycle pulse reopening reception |
| rxInhibit | output | 1 | Receive path closed |
| replyValid | output | 1 | A reply is to be sent this cycle |
| replyAck | output | 1 | 1 = ACK, 0 = NAK, valid with replyValid |
| pktRcvd | output | 1 | One-cycle pulse: packet received |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | 9 | Buffer write address |
| bufWrData | output | 8 | Buffer write data |

## Verification
The two functions that can fall in the same cycle are software's clear of the inhibit flag and the hardware's own use of that flag. Either the flag is set by a packet that passes both checks, or it is read to choose between ACK and NAK for an enquiry. The bench provokes both by raising clrInhibit on the very cycle of rxEnd: once at the end of a good unicast packet and once at the end of an enquiry while the flag is set. A behavioural reference model judges the result every clock. Directed checks then confirm that the set wins over the clear and that the enquiry sees the flag's value before the clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [7:0] SOH_CODE = 8'h01;
  localparam logic [7:0] ENQ_CODE = 8'h85;
  localparam logic [7:0] BCAST_ID = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENQ_DID,
    ST_ENQ_WAIT,
    ST_DAT_SID,
    ST_DAT_DID,
    ST_DAT_BODY,
    ST_SKIP
  } rxf_state_e;

  typedef struct packed {
    logic latchSid;
    logic writeSid;
    logic writeBody;
    logic enqReply;
    logic markRcvd;
    logic ackData;
  } rxf_strobe_t;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int MAX_LEN = 507
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       myId,
  input  logic             bcastEn,
  input  logic             rcvAll,
  input  logic             rxValid,
  input  logic             rxFirst,
  input  logic [7:0]       rxData,
  input  logic             rxEnd,
  input  logic             rxCrcGood,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             inhibit,
  output rxf_strobe_t      strb
);

  rxf_state_e state, nextState;
  logic enqHitQ, bcastQ;
  logic didMatch, lenOk;

  assign lenOk    = (rxLen <= LEN_W'(MAX_LEN));
  assign didMatch = !inhibit &&
                    (rcvAll || (rxData == myId) || ((rxData == BCAST_ID) && bcastEn));

  always_comb begin
    nextState = state;
    strb      = '0;
    if (rxEnd) begin
      nextState = ST_IDLE;
      if (state == ST_ENQ_WAIT && enqHitQ) begin
        strb.enqReply = 1'b1;
      end
      if (state == ST_DAT_BODY && rxCrcGood && lenOk) begin
        strb.markRcvd = 1'b1;
        strb.ackData  = !bcastQ;
      end
    end else if (rxValid && rxFirst) begin
      if (rxData == ENQ_CODE)      nextState = ST_ENQ_DID;
      else if (rxData == SOH_CODE) nextState = ST_DAT_SID;
      else                         nextState = ST_SKIP;
    end else if (rxValid) begin
      case (state)
        ST_ENQ_DID:  nextState = ST_ENQ_WAIT;
        ST_DAT_SID: begin
          strb.latchSid = 1'b1;
          nextState     = ST_DAT_DID;
        end
        ST_DAT_DID: begin
          if (didMatch) begin
            strb.writeSid = 1'b1;
            nextState     = ST_DAT_BODY;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_DAT_BODY: strb.writeBody = 1'b1;
        default:     nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      enqHitQ <= 1'b0;
      bcastQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (rxValid && !rxFirst && !rxEnd && state == ST_ENQ_DID) begin
        enqHitQ <= (rxData == myId);
      end
      if (rxValid && !rxFirst && !rxEnd && state == ST_DAT_DID) begin
        bcastQ <= (rxData == BCAST_ID);
      end
    end
  end

  // R9: no acceptance while the receive path is closed
  p_no_accept_inhibited_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeSid |-> !inhibit);

  // R6: a received mark only ever follows an accepted frame
  p_rcvd_after_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.markRcvd |-> (state == ST_DAT_BODY));

endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath
  import rxf_pkg::*;
#(
  parameter int MAX_LEN = 507,
  parameter int ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxf_strobe_t       strb,
  input  logic [7:0]        rxData,
  input  logic              clrInhibit,
  output logic              inhibitQ,
  output logic              replyValid,
  output logic              replyAck,
  output logic              pktRcvd,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData
);

  localparam int BUF_DEPTH = MAX_LEN + 1;

  logic [7:0]      sidQ;
  logic [ADDR_W:0] nextAddr;
  logic            roomLeft;

  assign roomLeft = (nextAddr < (ADDR_W+1)'(BUF_DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sidQ      <= '0;
      nextAddr  <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
    end else begin
      bufWrEn <= 1'b0;
      if (strb.latchSid) begin
        sidQ <= rxData;
      end
      if (strb.writeSid) begin
        bufWrEn   <= 1'b1;
        bufWrAddr <= '0;
        bufWrData <= sidQ;
        nextAddr  <= (ADDR_W+1)'(1);
      end else if (strb.writeBody && roomLeft) begin
        bufWrEn   <= 1'b1;
        bufWrAddr <= nextAddr[ADDR_W-1:0];
        bufWrData <= rxData;
        nextAddr  <= nextAddr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inhibitQ   <= 1'b0;
      replyValid <= 1'b0;
      replyAck   <= 1'b0;
      pktRcvd    <= 1'b0;
    end else begin
      pktRcvd <= strb.markRcvd;
      if (strb.enqReply) begin
        replyValid <= 1'b1;
        replyAck   <= !inhibitQ;
      end else if (strb.markRcvd && strb.ackData) begin
        replyValid <= 1'b1;
        replyAck   <= 1'b1;
      end else begin
        replyValid <= 1'b0;
        replyAck   <= 1'b0;
      end
      if (strb.markRcvd)  inhibitQ <= 1'b1;
      else if (clrInhibit) inhibitQ <= 1'b0;
    end
  end

  // R2: enquiry answered NAK while closed, ACK while open
  p_enq_nak_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.enqReply && inhibitQ |=> replyValid && !replyAck);
  p_enq_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.enqReply && !inhibitQ |=> replyValid && replyAck);

  // R10: set beats clear, clear alone reopens
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.markRcvd |=> inhibitQ);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clrInhibit && !strb.markRcvd |=> !inhibitQ);

  // R8: without a mark or a clear the flag holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.markRcvd && !clrInhibit |=> $stable(inhibitQ));

  // R11: writes stay inside the buffer
  p_addr_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (int'(bufWrAddr) <= MAX_LEN));

endmodule

// File: rtl/rx_filter_ack.sv
module rx_filter_ack
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int MAX_LEN = 507,
  localparam int ADDR_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        myId,
  input  logic              bcastEn,
  input  logic              rcvAll,
  input  logic              rxValid,
  input  logic              rxFirst,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic              rxCrcGood,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic              clrInhibit,
  output logic              rxInhibit,
  output logic              replyValid,
  output logic              replyAck,
  output logic              pktRcvd,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData
);

  rxf_strobe_t strb;
  logic        inhibitQ;

  assign rxInhibit = inhibitQ;

  rxf_ctrl #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .myId(myId), .bcastEn(bcastEn), .rcvAll(rcvAll),
    .rxValid(rxValid), .rxFirst(rxFirst), .rxData(rxData), .rxEnd(rxEnd),
    .rxCrcGood(rxCrcGood), .rxLen(rxLen), .inhibit(inhibitQ), .strb(strb)
  );

  rxf_dpath #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .clrInhibit(clrInhibit), .inhibitQ(inhibitQ), .replyValid(replyValid),
    .replyAck(replyAck), .pktRcvd(pktRcvd), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

endmodule

// File: tb/tb_rx_filter_ack.sv
module tb_rx_filter_ack;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] myId = 8'h2A;
  logic       bcastEn = 1'b0, rcvAll = 1'b0;
  logic       rxValid = 1'b0, rxFirst = 1'b0, rxEnd = 1'b0, rxCrcGood = 1'b0;
  logic [7:0] rxData = '0;
  logic [9:0] rxLen = '0;
  logic       clrInhibit = 1'b0;
  logic       rxInhibit, replyValid, replyAck, pktRcvd, bufWrEn;
  logic [8:0] bufWrAddr;
  logic [7:0] bufWrData;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  rx_filter_ack dut (
    .clk(clk), .rstN(rstN), .myId(myId), .bcastEn(bcastEn), .rcvAll(rcvAll),
    .rxValid(rxValid), .rxFirst(rxFirst), .rxData(rxData), .rxEnd(rxEnd),
    .rxCrcGood(rxCrcGood), .rxLen(rxLen), .clrInhibit(clrInhibit),
    .rxInhibit(rxInhibit), .replyValid(replyValid), .replyAck(replyAck),
    .pktRcvd(pktRcvd), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // reference model: frame kind and byte index, decided per byte
  int  kind = -1, idx = 0;
  bit  enqHit, acc, isB, mInh, setI;
  bit [7:0] sid;
  bit  eWr, eRv, eAck, ePkt;
  int  eAddr, eData;

  always @(posedge clk) begin
    eWr = 0; eRv = 0; eAck = 0; ePkt = 0; setI = 0;
    if (!rstN) begin
      kind = -1; mInh = 0;
    end else begin
      if (rxEnd) begin
        if (kind == 'h85 && enqHit) begin eRv = 1; eAck = !mInh; end
        if (kind == 'h01 && acc && rxCrcGood && rxLen <= 507) begin
          ePkt = 1; setI = 1;
          if (!isB) begin eRv = 1; eAck = 1; end
        end
        kind = -1;
      end else if (rxValid) begin
        if (rxFirst) begin
          kind = int'(rxData); idx = 0; enqHit = 0; acc = 0;
        end else if (kind >= 0) begin
          idx++;
          if (kind == 'h85 && idx == 1) enqHit = (rxData == myId);
          if (kind == 'h01) begin
            if (idx == 1) sid = rxData;
            else if (idx == 2) begin
              acc = !mInh && (rcvAll || rxData == myId || (rxData == 0 && bcastEn));
              isB = (rxData == 0);
              if (acc) begin eWr = 1; eAddr = 0; eData = int'(sid); end
            end else if (acc && idx - 2 <= 507) begin
              eWr = 1; eAddr = idx - 2; eData = int'(rxData);
            end
          end
        end
      end
      if (setI) mInh = 1;
      else if (clrInhibit) mInh = 0;
    end
  end

  int wrCnt, rvCnt, ackCnt, pktCnt, maxAddr;

  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      chk(rxInhibit == mInh, "R10 rxInhibit vs model", rxInhibit, mInh);
      chk(pktRcvd == ePkt, "R6 pktRcvd vs model", pktRcvd, ePkt);
      chk(replyValid == eRv, "R2 replyValid vs model", replyValid, eRv);
      if (eRv) chk(replyAck == eAck, "R2 replyAck vs model", replyAck, eAck);
      chk(bufWrEn == eWr, "R5 bufWrEn vs model", bufWrEn, eWr);
      if (eWr && bufWrEn) begin
        chk(int'(bufWrAddr) == eAddr, "R5 bufWrAddr vs model", bufWrAddr, eAddr);
        chk(int'(bufWrData) == eData, "R5 bufWrData vs model", bufWrData, eData);
      end
      if (bufWrEn) begin
        wrCnt++;
        if (int'(bufWrAddr) > maxAddr) maxAddr = int'(bufWrAddr);
      end
      if (replyValid) begin rvCnt++; if (replyAck) ackCnt++; end
      if (pktRcvd) pktCnt++;
    end
  end

  task automatic clrCnt();
    wrCnt = 0; rvCnt = 0; ackCnt = 0; pktCnt = 0; maxAddr = -1;
  endtask

  task automatic sendData(input logic [7:0] lead, input logic [7:0] s, input logic [7:0] d,
                          input int n, input bit crc, input int len, input bit clrEnd);
    clrCnt();
    @(negedge clk) rxValid = 1; rxFirst = 1; rxData = lead;
    @(negedge clk) rxFirst = 0; rxData = s;
    @(negedge clk) rxData = d;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxData = 8'(i * 7 + 3);
    end
    @(negedge clk) rxValid = 0; rxEnd = 1; rxCrcGood = crc; rxLen = 10'(len); clrInhibit = clrEnd;
    @(negedge clk) rxEnd = 0; rxCrcGood = 0; clrInhibit = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendEnq(input logic [7:0] d, input bit clrEnd);
    clrCnt();
    @(negedge clk) rxValid = 1; rxFirst = 1; rxData = 8'h85;
    @(negedge clk) rxFirst = 0; rxData = d;
    @(negedge clk) rxData = d;
    @(negedge clk) rxValid = 0; rxEnd = 1; clrInhibit = clrEnd;
    @(negedge clk) rxEnd = 0; clrInhibit = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseClr();
    @(negedge clk) clrInhibit = 1;
    @(negedge clk) clrInhibit = 0;
    @(negedge clk);
  endtask

  initial begin
    clrCnt();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rxInhibit && !replyValid && !replyAck && !pktRcvd && !bufWrEn, "R1 outputs in reset",
        {rxInhibit, replyValid, replyAck, pktRcvd, bufWrEn}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk(rxInhibit == 0, "R1 rxInhibit after reset", rxInhibit, 0);

    sendEnq(8'h2A, 0);
    chk(rvCnt == 1 && ackCnt == 1, "R2 enquiry open gets ACK", ackCnt, 1);
    sendEnq(8'h33, 0);
    chk(rvCnt == 0, "R2 enquiry to other ID no reply", rvCnt, 0);

    sendData(8'h55, 8'h11, 8'h2A, 3, 1, 3, 0);
    chk(wrCnt == 0 && rvCnt == 0 && pktCnt == 0, "R3 unknown lead byte ignored", wrCnt, 0);

    sendData(8'h01, 8'h11, 8'h2A, 3, 1, 3, 0);
    chk(wrCnt == 4 && maxAddr == 3, "R5 unicast writes", wrCnt, 4);
    chk(pktCnt == 1 && ackCnt == 1 && rxInhibit, "R6 unicast received and ACKed", pktCnt, 1);

    sendEnq(8'h2A, 0);
    chk(rvCnt == 1 && ackCnt == 0, "R2 enquiry inhibited gets NAK", ackCnt, 0);
    sendData(8'h01, 8'h12, 8'h2A, 2, 1, 2, 0);
    chk(wrCnt == 0 && pktCnt == 0, "R9 no writes while inhibited", wrCnt, 0);

    pulseClr();
    chk(rxInhibit == 0, "R10 clear pulse reopens", rxInhibit, 0);

    bcastEn = 1;
    sendData(8'h01, 8'h13, 8'h40, 2, 1, 2, 0);
    chk(wrCnt == 0, "R4 other destination ignored", wrCnt, 0);
    bcastEn = 0;
    sendData(8'h01, 8'h14, 8'h00, 2, 1, 2, 0);
    chk(wrCnt == 0, "R4 broadcast ignored when disabled", wrCnt, 0);
    bcastEn = 1;
    sendData(8'h01, 8'h15, 8'h00, 2, 1, 2, 0);
    chk(wrCnt == 3 && pktCnt == 1, "R4 broadcast accepted when enabled", wrCnt, 3);
    chk(rvCnt == 0 && rxInhibit, "R7 broadcast silent", rvCnt, 0);
    pulseClr();
    bcastEn = 0;

    sendData(8'h01, 8'h16, 8'h2A, 4, 0, 4, 0);
    chk(wrCnt == 5 && pktCnt == 0 && rvCnt == 0 && !rxInhibit, "R8 bad CRC rejected", pktCnt, 0);
    sendData(8'h01, 8'h17, 8'h2A, 4, 1, 508, 0);
    chk(pktCnt == 0 && rvCnt == 0 && !rxInhibit, "R8 length 508 rejected", pktCnt, 0);

    sendData(8'h01, 8'h18, 8'h2A, 0, 1, 0, 0);
    chk(pktCnt == 1 && wrCnt == 1 && ackCnt == 1, "R6 zero length accepted", pktCnt, 1);
    pulseClr();

    rcvAll = 1;
    sendData(8'h01, 8'h19, 8'h77, 2, 1, 2, 0);
    chk(wrCnt == 3 && pktCnt == 1 && ackCnt == 1, "R4 monitor mode accepts any ID", wrCnt, 3);
    rcvAll = 0;
    pulseClr();

    sendData(8'h01, 8'h1A, 8'h2A, 1, 1, 1, 1);
    chk(rxInhibit == 1 && pktCnt == 1, "R10 set wins over same-cycle clear", rxInhibit, 1);
    sendEnq(8'h2A, 1);
    chk(rvCnt == 1 && ackCnt == 0, "R10 enquiry with same-cycle clear gets NAK", ackCnt, 0);
    chk(rxInhibit == 0, "R10 clear after enquiry", rxInhibit, 0);

    sendData(8'h01, 8'h1B, 8'h2A, 510, 1, 510, 0);
    chk(maxAddr == 507 && wrCnt == 508, "R11 writes stop at 507", maxAddr, 507);
    chk(pktCnt == 0 && !rxInhibit, "R8 overlong packet rejected", pktCnt, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule